// File: doc/BRIEF.md
# Big-Endian Byte and Word Memory Access Aligner

This block sits between a processor's load/store stage and a data memory that is one 32-bit word wide and accepts a byte-lane write strobe. Each request gives a base register value, a signed 16-bit displacement, an operation code, and the source register value for stores. The block adds the base and the sign-extended displacement to form a byte address. It registers one memory command that carries the word address, a four-lane write strobe and the store data placed in its lane.

Lanes are mapped big-endian: byte offset 0 inside a word is the most significant byte. Byte stores assert only one strobe. Byte loads pick the addressed lane from the returned word and sign-extend it to 32 bits. Word loads pass the whole word through. A word access whose byte address is not a multiple of four raises a one-cycle misalignment flag and issues no memory command.

The memory is expected to return read data on the clock edge after the command. The load result is therefore valid in the cycle after a read command.

Top module: `be_mem_aligner`

## Requirements
- R1: The byte address is `req_base` plus `req_off` sign-extended to 32 bits. On the edge that captures a valid request, `mem_addr` becomes that address with its two low bits dropped.
- R2: The operation codes on `req_op` are 00 load word, 01 load byte, 10 store word and 11 store byte. Bit 1 selects a store and bit 0 selects a byte access.
- R3: An aligned word store issues `mem_req`=1, `mem_we`=1, `mem_be`=1111 and `mem_wdata`=`req_src`.
- R4: A byte store asserts exactly one strobe, selected by address bits 1:0. Offset 0 gives `mem_be`=1000 and drives bits 31:24, offset 1 gives 0100 and bits 23:16, offset 2 gives 0010 and bits 15:8, and offset 3 gives 0001 and bits 7:0. The addressed lane of `mem_wdata` carries `req_src[7:0]`, and the other three bytes of the memory word stay unchanged.
- R5: A byte load returns the addressed byte, under the same lane mapping as R4, in `ld_data[7:0]`. Bits 31:8 are copies of that byte's bit 7.
- R6: A word load returns `mem_rdata` unchanged on `ld_data`.
- R7: `ld_valid` is high for one cycle: the cycle after a read command, while `mem_rdata` holds the addressed word.
- R8: A word load or store whose address bits 1:0 are not 00 sets `misalign` for one cycle and issues no command (`mem_req`=0), and no `ld_valid` follows. Byte accesses never set `misalign`.
- R9: With `req_valid` low at an edge, the following cycle has `mem_req`=0 and `misalign`=0.
- R10: Synchronous active-high reset clears `mem_req`, `mem_we`, `mem_be`, `misalign` and `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed displacement |
| req_src | input | 32 | Source register value for stores |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane write strobe, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read word returned one edge after a read command |
| misalign | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
The hardest case to reach is proving that the three lanes a byte store does not own keep their values. That cannot be seen on the command alone. The bench stores into every offset of a word that holds distinct bytes, reads the word back, and then loads every byte of it. A negative displacement is combined with a base whose low bits are nonzero, so the sign extension and the carry into the lane bits both matter. The misaligned word cases are sent directly after valid loads, to show that no stray result follows them.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        OP_LDW = 2'b00,
        OP_LDB = 2'b01,
        OP_STW = 2'b10,
        OP_STB = 2'b11
    } acc_op_e;

    typedef struct packed {
        logic              is_store;
        logic              is_byte;
    } acc_kind_t;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } lane_put_t;

    function automatic acc_kind_t decode_op(input logic [1:0] op);
        acc_kind_t k;
        k.is_store = op[1];
        k.is_byte  = op[0];
        return k;
    endfunction

    // big-endian: lane index 0 is the top byte of the word
    function automatic int unsigned lane_lsb(input logic [LANE_W-1:0] lane);
        return 8 * (LANES - 1 - int'(lane));
    endfunction

endpackage

// File: rtl/be_ea_gen.sv
module be_ea_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  logic              word_acc,
    output logic [ADDR_W-1:0] ea,
    output logic              bad_align
);
    import be_align_pkg::*;

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext   = {{EXT_W{off[OFF_W-1]}}, off};
        ea        = base + off_ext;
        bad_align = word_acc && (ea[LANE_W-1:0] != '0);
    end

endmodule

// File: rtl/be_store_lane.sv
module be_store_lane (
    input  logic [be_align_pkg::DATA_W-1:0] src,
    input  logic [be_align_pkg::LANE_W-1:0] lane,
    input  logic                            byte_acc,
    output be_align_pkg::lane_put_t         put
);
    import be_align_pkg::*;

    always_comb begin
        put.be    = '0;
        put.wdata = src;
        if (byte_acc) begin
            for (int i = 0; i < LANES; i++) begin
                put.wdata[8*i +: 8] = src[7:0];
            end
            put.be[LANES-1-int'(lane)] = 1'b1;
        end else begin
            put.be = '1;
        end
    end

endmodule

// File: rtl/be_load_extract.sv
module be_load_extract (
    input  logic [be_align_pkg::DATA_W-1:0] rdata,
    input  logic [be_align_pkg::LANE_W-1:0] lane,
    input  logic                            byte_acc,
    output logic [be_align_pkg::DATA_W-1:0] result
);
    import be_align_pkg::*;

    logic [7:0] picked;

    always_comb begin
        picked = rdata[lane_lsb(lane) +: 8];
        if (byte_acc) begin
            result = {{(DATA_W-8){picked[7]}}, picked};
        end else begin
            result = rdata;
        end
    end

endmodule

// File: rtl/be_mem_aligner.sv
module be_mem_aligner #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [31:0]         req_src,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [3:0]          mem_be,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata,
    output logic                misalign,
    output logic                ld_valid,
    output logic [31:0]         ld_data
);
    import be_align_pkg::*;

    localparam int WADDR_W = ADDR_W - LANE_W;

    acc_kind_t           kind;
    logic [ADDR_W-1:0]   ea;
    logic                bad_align;
    lane_put_t           put;
    logic [LANE_W-1:0]   ea_lane;

    logic                cmd_byte_q;
    logic                rsp_byte_q;
    logic [LANE_W-1:0]   cmd_lane_q;
    logic [LANE_W-1:0]   rsp_lane_q;

    assign kind    = decode_op(req_op);
    assign ea_lane = ea[LANE_W-1:0];

    be_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
        .base      (req_base),
        .off       (req_off),
        .word_acc  (!kind.is_byte),
        .ea        (ea),
        .bad_align (bad_align)
    );

    be_store_lane u_st (
        .src      (req_src),
        .lane     (ea_lane),
        .byte_acc (kind.is_byte),
        .put      (put)
    );

    // command stage
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_be     <= '0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            misalign   <= 1'b0;
            cmd_byte_q <= 1'b0;
            cmd_lane_q <= '0;
        end else begin
            mem_req    <= req_valid && !bad_align;
            mem_we     <= req_valid && !bad_align && kind.is_store;
            mem_be     <= (req_valid && !bad_align && kind.is_store) ? put.be : '0;
            mem_addr   <= ea[ADDR_W-1:LANE_W];
            mem_wdata  <= put.wdata;
            misalign   <= req_valid && bad_align;
            cmd_byte_q <= kind.is_byte;
            cmd_lane_q <= ea_lane;
        end
    end

    // response stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid   <= 1'b0;
            rsp_byte_q <= 1'b0;
            rsp_lane_q <= '0;
        end else begin
            ld_valid   <= mem_req && !mem_we;
            rsp_byte_q <= cmd_byte_q;
            rsp_lane_q <= cmd_lane_q;
        end
    end

    be_load_extract u_ld (
        .rdata    (mem_rdata),
        .lane     (rsp_lane_q),
        .byte_acc (rsp_byte_q),
        .result   (ld_data)
    );

    // R8: a flagged access never issues a command
    a_r8_no_cmd_on_misalign: assert property (@(posedge clk) disable iff (rst)
        misalign |-> !mem_req);

    // R7: every read command is followed by exactly one load result
    a_r7_read_gives_result: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> ld_valid);

    // R7: no load result without a read command before it
    a_r7_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !mem_we) |=> !ld_valid);

    // R4/R3: a write strobes one lane or all four
    a_r4_strobe_shape: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

    // R9: an idle cycle produces neither command nor flag
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_req && !misalign));

    // R8: byte requests never flag misalignment
    a_r8_byte_never_flagged: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[0]) |=> !misalign);

endmodule

// File: tb/be_mem_aligner_tb.sv
module be_mem_aligner_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [31:0] req_base;
    logic [15:0] req_off;
    logic [31:0] req_src;
    logic        mem_req, mem_we, misalign, ld_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata, ld_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  ref_mem [0:255];
    logic [31:0] mem     [0:63];

    always #2 clk = ~clk;

    be_mem_aligner u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_off(req_off), .req_src(req_src),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // bench memory, one edge read latency, strobe bit 3 = bits 31:24
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:0]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected load results
    always @(negedge clk) begin
        if (!rst && ld_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected ld_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), ld_data, exp_q.pop_front());
            end
        end
    end

    // driver: issue one request and check the command in the next cycle
    task automatic do_op(input logic [1:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] src);
        logic [31:0] ea;
        logic [7:0]  a;
        logic        bad;
        ea  = base + {{16{off[15]}}, off};
        a   = ea[7:0];
        bad = !op[0] && (ea[1:0] != 2'b00);
        req_valid = 1'b1; req_op = op; req_base = base; req_off = off; req_src = src;
        if (!bad && !op[1]) begin
            if (op[0]) begin
                exp_q.push_back({{24{ref_mem[a][7]}}, ref_mem[a]});
                tag_q.push_back("R5 byte load");
            end else begin
                exp_q.push_back({ref_mem[a], ref_mem[a+8'd1], ref_mem[a+8'd2], ref_mem[a+8'd3]});
                tag_q.push_back("R6 word load");
            end
        end
        if (!bad && op[1]) begin
            if (op[0]) ref_mem[a] = src[7:0];
            else begin
                ref_mem[a] = src[31:24]; ref_mem[a+8'd1] = src[23:16];
                ref_mem[a+8'd2] = src[15:8]; ref_mem[a+8'd3] = src[7:0];
            end
        end
        @(negedge clk);
        if (bad) begin
            check("R8 misalign flag", {31'd0, misalign}, 32'd1);
            check("R8 no command", {31'd0, mem_req}, 32'd0);
        end else begin
            check("R1 word address", {2'b00, mem_addr}, {2'b00, ea[31:2]});
            check("R8 byte/aligned no flag", {31'd0, misalign}, 32'd0);
            check("R2 write enable", {31'd0, mem_we}, {31'd0, op[1]});
            if (op == 2'b10) begin
                check("R3 word strobe", {28'd0, mem_be}, 32'hF);
                check("R3 word data", mem_wdata, src);
            end
            if (op == 2'b11) begin
                check("R4 byte strobe", {28'd0, mem_be}, {28'd0, 4'b1000 >> ea[1:0]});
                check("R4 lane data", {24'd0, mem_wdata[8*(3-ea[1:0]) +: 8]}, {24'd0, src[7:0]});
            end
        end
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 idle no command", {31'd0, mem_req}, 32'd0);
        check("R9 idle no flag", {31'd0, misalign}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 256; b++) ref_mem[b] = 8'(b * 37 + 5);
        for (int w = 0; w < 64; w++)
            mem[w] = {ref_mem[4*w], ref_mem[4*w+1], ref_mem[4*w+2], ref_mem[4*w+3]};
        mem_rdata = '0;
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_base = '0; req_off = '0; req_src = '0;
        repeat (3) @(negedge clk);
        check("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
        check("R10 reset mem_we", {31'd0, mem_we}, 32'd0);
        check("R10 reset mem_be", {28'd0, mem_be}, 32'd0);
        check("R10 reset misalign", {31'd0, misalign}, 32'd0);
        check("R10 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        rst = 1'b0;
        idle();
        // word loads, positive and negative displacement (R1, R6)
        do_op(2'b00, 32'h1000_0040, 16'h0010, '0);
        do_op(2'b00, 32'h1000_0080, 16'hFFF0, '0);
        // byte loads of each lane, including sign extension (R5)
        for (int k = 0; k < 4; k++) do_op(2'b01, 32'h2000_0021, 16'(k + 3), '0);
        for (int k = 0; k < 8; k++) do_op(2'b01, 32'h0000_0013, 16'(-k), '0);
        // word store then readback (R3)
        do_op(2'b10, 32'h0000_0060, 16'h0000, 32'hA1B2_C3D4);
        do_op(2'b00, 32'h0000_0060, 16'h0000, '0);
        // byte stores into each lane, untouched lanes checked by readback (R4)
        do_op(2'b11, 32'h0000_0065, 16'hFFFF, 32'h1234_5680);
        do_op(2'b00, 32'h0000_0064, 16'h0000, '0);
        do_op(2'b11, 32'h0000_0062, 16'h0003, 32'hFFFF_FF7E);
        do_op(2'b00, 32'h0000_0064, 16'h0000, '0);
        do_op(2'b11, 32'h0000_0066, 16'h0000, 32'h0000_00C3);
        do_op(2'b11, 32'h0000_006A, 16'hFFFD, 32'h0000_0011);
        do_op(2'b00, 32'h0000_0064, 16'h0000, '0);
        for (int k = 0; k < 4; k++) do_op(2'b01, 32'h0000_0064, 16'(k), '0);
        // misaligned word accesses right after loads (R8)
        do_op(2'b00, 32'h0000_0070, 16'h0001, '0);
        do_op(2'b00, 32'h0000_0070, 16'h0000, '0);
        do_op(2'b10, 32'h0000_0070, 16'h0002, 32'hDEAD_BEEF);
        do_op(2'b10, 32'h0000_0073, 16'hFFFF, 32'hDEAD_BEEF);
        do_op(2'b00, 32'h0000_0070, 16'h0000, '0);
        do_op(2'b00, 32'h0000_0070, 16'h0004, '0);
        idle();
        idle();
        check("R7 all results seen", exp_q.size(), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule